// File: doc/BRIEF.md
# Page-Local Program Counter and Flag Branch Unit

This block sequences instruction fetch for a horizontally microcoded machine. It sends a 16-bit address to the program ROM and captures the returned 32-bit word in an instruction register. The upper 24 bits of that word are raw control lines and the lower 8 bits are an immediate. The control lines go to the datapath with no decoding between the register and the lines.

Only the low address byte counts. The page byte has no incrementer, so running past offset 0xFF wraps to offset 0x00 of the same page. Code reaches another page only through a long jump, which takes the page byte from the temp register T and the offset from the data bus.

Three conditional strobes load only the offset. Each tests one status condition of T: T equal to zero, T bit 4 (half carry) or T bit 7 (sign). Fetch is pipelined. A jump word is acted on while the next word is being fetched, so the word after every jump always executes.

Top module: `page_pc_unit`

## Requirements
- R1: While reset is high and just after it, `rom_addr` is 0x0000, `ctrl_lines` is the idle value 0xF00000 (all four jump strobes high, every other line low) and `imm_val` is 0x00.
- R2: In a cycle where the instruction register requests no taken jump, the next `rom_addr` keeps its page byte (bits 15:8) and its offset byte (bits 7:0) grows by one.
- R3: An offset of 0xFF with no taken jump is followed by offset 0x00 in the same page.
- R4: When control line 20 (the long-jump strobe, active low) is low in the instruction register, the next `rom_addr` is {`t_val`, `bus_val`}, with both values sampled in that cycle. This is the only way the page byte changes.
- R5: When control line 21 (zero strobe, active low) is the selected strobe, the next offset is `bus_val` if `t_val` is 0x00. Otherwise the offset increments.
- R6: When control line 22 (half-carry strobe, active low) is the selected strobe, the next offset is `bus_val` if bit 4 of `t_val` is 1. Otherwise the offset increments.
- R7: When control line 23 (sign strobe, active low) is the selected strobe, the next offset is `bus_val` if bit 7 of `t_val` is 1. Otherwise the offset increments.
- R8: The instruction register captures every fetched word. One cycle after the word is fetched, word bits 31:8 appear unchanged on `ctrl_lines` and bits 7:0 appear on `imm_val`.
- R9: The word at the address just after a jump word is always loaded into the instruction register, whether or not the jump is taken.
- R10: If several strobes are low at once, only the highest priority one decides the outcome. The order is long jump, then zero, then half carry, then sign. A lower priority strobe whose condition holds has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rom_word | input | 32 | Word read from program ROM at `rom_addr` |
| bus_val | input | 8 | Data bus value; offset target for jumps |
| t_val | input | 8 | Temp register value; page byte for long jumps and status bits for conditions |
| rom_addr | output | 16 | Program counter, used as the ROM address |
| ctrl_lines | output | 24 | Raw control lines held in the instruction register |
| imm_val | output | 8 | Immediate field held in the instruction register |

## Verification
Two functions can fall in the same cycle: the page wrap and a jump decision. This happens when a jump word sits at offset 0xFE, so the jump is resolved while the counter stands at 0xFF. The bench places a zero-test jump there twice. When the jump is taken, the result must be the bus offset in the same page. When it is not taken, the result must wrap to offset 0x00 of the same page. In both cases the word at 0xFF must still appear in the instruction register.

// File: rtl/pgpc_pkg.sv
package pgpc_pkg;

    localparam int PAGE_W  = 8;
    localparam int ADDR_W  = 2 * PAGE_W;
    localparam int IMM_W   = 8;
    localparam int CTRL_W  = 24;
    localparam int WORD_W  = CTRL_W + IMM_W;
    localparam int N_COND  = 3;

    // strobe positions inside the control field (active low)
    localparam int STB_LONG = 20;
    localparam int STB_ZERO = 21;
    localparam int STB_HALF = 22;
    localparam int STB_SIGN = 23;

    localparam int T_HALF_BIT = 4;
    localparam int T_SIGN_BIT = 7;

    localparam logic [CTRL_W-1:0] CTRL_IDLE = 24'hF0_0000;

    typedef enum logic [2:0] {
        JK_NONE,
        JK_LONG,
        JK_ZERO,
        JK_HALF,
        JK_SIGN
    } jump_kind_e;

    typedef struct packed {
        logic [CTRL_W-1:0] ctrl;
        logic [IMM_W-1:0]  imm;
    } iword_t;

    typedef struct packed {
        logic take_lo;
        logic take_hi;
    } pc_load_t;

    // conditional strobes in priority order: index 0 wins
    function automatic int cond_strobe(int idx);
        case (idx)
            0:       return STB_ZERO;
            1:       return STB_HALF;
            default: return STB_SIGN;
        endcase
    endfunction

    function automatic jump_kind_e cond_kind(int idx);
        case (idx)
            0:       return JK_ZERO;
            1:       return JK_HALF;
            default: return JK_SIGN;
        endcase
    endfunction

    function automatic int cond_tbit(int idx);
        return (idx == 1) ? T_HALF_BIT : T_SIGN_BIT;
    endfunction

endpackage

// File: rtl/pgpc_instr_reg.sv
module pgpc_instr_reg
    import pgpc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [WORD_W-1:0] fetch_word,
    output iword_t            ir_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            ir_q.ctrl <= CTRL_IDLE;
            ir_q.imm  <= '0;
        end else begin
            ir_q <= iword_t'(fetch_word);
        end
    end

endmodule

// File: rtl/pgpc_branch_resolve.sv
module pgpc_branch_resolve
    import pgpc_pkg::*;
#(
    parameter int PW = PAGE_W
) (
    input  logic [CTRL_W-1:0] ctrl,
    input  logic [PW-1:0]     t_val,
    output pc_load_t          load
);

    logic [N_COND-1:0] cond_req;
    logic [N_COND-1:0] cond_met;
    jump_kind_e        kind;
    logic              sel_met;

    for (genvar g = 0; g < N_COND; g++) begin : g_cond
        assign cond_req[g] = ~ctrl[cond_strobe(g)];
        if (g == 0) begin : g_zero
            assign cond_met[g] = (t_val == '0);
        end else begin : g_bit
            assign cond_met[g] = t_val[cond_tbit(g)];
        end
    end

    // pick the single strobe that decides, by priority
    always_comb begin
        kind    = JK_NONE;
        sel_met = 1'b0;
        if (!ctrl[STB_LONG]) begin
            kind    = JK_LONG;
            sel_met = 1'b1;
        end else begin
            for (int i = N_COND - 1; i >= 0; i--) begin
                if (cond_req[i]) begin
                    kind    = cond_kind(i);
                    sel_met = cond_met[i];
                end
            end
        end
    end

    always_comb begin
        load = '0;
        case (kind)
            JK_LONG: begin
                load.take_lo = 1'b1;
                load.take_hi = 1'b1;
            end
            JK_ZERO, JK_HALF, JK_SIGN: load.take_lo = sel_met;
            default: load = '0;
        endcase
    end

endmodule

// File: rtl/pgpc_page_counter.sv
module pgpc_page_counter
    import pgpc_pkg::*;
#(
    parameter int PW = PAGE_W
) (
    input  logic          clk,
    input  logic          rst,
    input  pc_load_t      load,
    input  logic [PW-1:0] lo_src,
    input  logic [PW-1:0] hi_src,
    output logic [2*PW-1:0] pc
);

    logic [PW-1:0] lo_q;
    logic [PW-1:0] hi_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            lo_q <= '0;
            hi_q <= '0;
        end else begin
            lo_q <= load.take_lo ? lo_src : lo_q + PW'(1);
            if (load.take_hi) begin
                hi_q <= hi_src;
            end
        end
    end

    assign pc = {hi_q, lo_q};

endmodule

// File: rtl/page_pc_unit.sv
module page_pc_unit
    import pgpc_pkg::*;
#(
    parameter int PW = PAGE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [WORD_W-1:0] rom_word,
    input  logic [PW-1:0]     bus_val,
    input  logic [PW-1:0]     t_val,
    output logic [2*PW-1:0]   rom_addr,
    output logic [CTRL_W-1:0] ctrl_lines,
    output logic [IMM_W-1:0]  imm_val
);

    iword_t   ir;
    pc_load_t load;

    pgpc_instr_reg u_ir (
        .clk        (clk),
        .rst        (rst),
        .fetch_word (rom_word),
        .ir_q       (ir)
    );

    pgpc_branch_resolve #(.PW(PW)) u_br (
        .ctrl  (ir.ctrl),
        .t_val (t_val),
        .load  (load)
    );

    pgpc_page_counter #(.PW(PW)) u_pc (
        .clk    (clk),
        .rst    (rst),
        .load   (load),
        .lo_src (bus_val),
        .hi_src (t_val),
        .pc     (rom_addr)
    );

    assign ctrl_lines = ir.ctrl;
    assign imm_val    = ir.imm;

endmodule

// File: rtl/page_pc_unit_chk.sv
module page_pc_unit_chk
    import pgpc_pkg::*;
#(
    parameter int PW = PAGE_W
) (
    input logic              clk,
    input logic              rst,
    input logic [WORD_W-1:0] rom_word,
    input logic [PW-1:0]     bus_val,
    input logic [PW-1:0]     t_val,
    input logic [2*PW-1:0]   rom_addr,
    input logic [CTRL_W-1:0] ctrl_lines,
    input logic [IMM_W-1:0]  imm_val
);

    logic long_on, zero_on, half_on, sign_on, lo_taken;

    assign long_on = !ctrl_lines[STB_LONG];
    assign zero_on = !ctrl_lines[STB_ZERO];
    assign half_on = !ctrl_lines[STB_HALF];
    assign sign_on = !ctrl_lines[STB_SIGN];
    assign lo_taken = long_on
                    || (zero_on ? (t_val == '0)
                       : half_on ? t_val[T_HALF_BIT]
                       : sign_on ? t_val[T_SIGN_BIT] : 1'b0);

    // R2
    incr_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !lo_taken |=> rom_addr[PW-1:0] == PW'($past(rom_addr[PW-1:0]) + 1'b1));

    // R3
    wrap_in_page_chk: assert property (@(posedge clk) disable iff (rst)
        (!lo_taken && rom_addr[PW-1:0] == '1)
        |=> (rom_addr[PW-1:0] == '0 && rom_addr[2*PW-1:PW] == $past(rom_addr[2*PW-1:PW])));

    // R4
    long_load_chk: assert property (@(posedge clk) disable iff (rst)
        long_on |=> rom_addr == {$past(t_val), $past(bus_val)});

    // R4
    page_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !long_on |=> $stable(rom_addr[2*PW-1:PW]));

    // R5 R6 R7
    cond_load_chk: assert property (@(posedge clk) disable iff (rst)
        (!long_on && lo_taken) |=> rom_addr[PW-1:0] == $past(bus_val));

    // R10
    zero_priority_chk: assert property (@(posedge clk) disable iff (rst)
        (!long_on && zero_on && t_val != '0)
        |=> rom_addr[PW-1:0] == PW'($past(rom_addr[PW-1:0]) + 1'b1));

    // R8
    ir_follow_chk: assert property (@(posedge clk) disable iff (rst)
        !rst |=> {ctrl_lines, imm_val} == $past(rom_word));

endmodule

bind page_pc_unit page_pc_unit_chk #(.PW(PW)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .rom_word   (rom_word),
    .bus_val    (bus_val),
    .t_val      (t_val),
    .rom_addr   (rom_addr),
    .ctrl_lines (ctrl_lines),
    .imm_val    (imm_val)
);

// File: tb/page_pc_unit_bench.sv
module page_pc_unit_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] rom_word;
    logic [7:0]  bus_val = 8'h00;
    logic [7:0]  t_val   = 8'h00;
    logic [15:0] rom_addr;
    logic [23:0] ctrl_lines;
    logic [7:0]  imm_val;

    logic        patch_on = 1'b0;
    logic [15:0] patch_a  = 16'h0000;
    logic [31:0] patch_w  = 32'h0;

    int n_chk  = 0;
    int n_fail = 0;

    localparam logic [23:0] IDLE = 24'hF0_0000;

    always #4 clk = ~clk;

    page_pc_unit u_page_pc_unit (
        .clk        (clk),
        .rst        (rst),
        .rom_word   (rom_word),
        .bus_val    (bus_val),
        .t_val      (t_val),
        .rom_addr   (rom_addr),
        .ctrl_lines (ctrl_lines),
        .imm_val    (imm_val)
    );

    // program model: idle control, immediate = offset of the address
    always_comb begin
        if (patch_on && rom_addr == patch_a) rom_word = patch_w;
        else                                 rom_word = {IDLE, rom_addr[7:0]};
    end

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // strobe nibble s = {sign, half, zero, long}, active low
    function automatic logic [15:0] ref_next(logic [15:0] cur, logic [3:0] s,
                                             logic [7:0] bus, logic [7:0] t);
        logic [7:0] pg, off;
        logic       tk;
        pg  = cur[15:8];
        off = cur[7:0] + 8'd1;
        if (!s[0]) return {t, bus};
        if (!s[1])      tk = (t == 8'h00);
        else if (!s[2]) tk = t[4];
        else if (!s[3]) tk = t[7];
        else            tk = 1'b0;
        return tk ? {pg, bus} : {pg, off + 8'd1};
    endfunction

    // place a jump word at the current address; starts and ends just after a falling edge
    task automatic jump_at(logic [3:0] s, logic [7:0] bus, logic [7:0] t, string req);
        logic [15:0] cur, exp;
        cur      = rom_addr;
        exp      = ref_next(cur, s, bus, t);
        patch_a  = cur;
        patch_w  = {s, 20'h0, 8'h5A};
        patch_on = 1'b1;
        bus_val  = bus;
        t_val    = t;
        @(negedge clk);
        chk({"R8 jump word in register ", req}, {8'h0, ctrl_lines}, {8'h0, s, 20'h0});
        @(negedge clk);
        chk(req, {16'h0, rom_addr}, {16'h0, exp});
        chk({"R9 slot executed ", req}, {24'h0, imm_val}, {24'h0, cur[7:0] + 8'd1});
        patch_on = 1'b0;
    endtask

    task automatic go_to(logic [15:0] target);
        jump_at(4'b1110, target[7:0], target[15:8], "R4 long jump");
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1 address", {16'h0, rom_addr}, 32'h0);
        chk("R1 control", {8'h0, ctrl_lines}, {8'h0, IDLE});
        chk("R1 immediate", {24'h0, imm_val}, 32'h0);
        rst = 1'b0;
    endtask

    task automatic t_count();
        for (int i = 1; i <= 5; i++) begin
            @(negedge clk);
            chk("R2 increment", {16'h0, rom_addr}, i);
            chk("R8 immediate follows fetch", {24'h0, imm_val}, i - 1);
        end
    endtask

    task automatic t_wrap();
        go_to(16'h34FD);
        @(negedge clk);
        chk("R2 offset FE", {16'h0, rom_addr}, 32'h34FE);
        @(negedge clk);
        chk("R2 offset FF", {16'h0, rom_addr}, 32'h34FF);
        @(negedge clk);
        chk("R3 wrap to same page", {16'h0, rom_addr}, 32'h3400);
        chk("R8 word from FF", {24'h0, imm_val}, 32'hFF);
        @(negedge clk);
        chk("R3 continues after wrap", {16'h0, rom_addr}, 32'h3401);
    endtask

    task automatic t_long();
        go_to(16'hA510);
        go_to(16'h57FF);
        jump_at(4'b1110, 8'h00, 8'h58, "R4 next page entry");
        jump_at(4'b1110, 8'hC3, 8'h00, "R4 back to page zero");
    endtask

    task automatic t_cond();
        jump_at(4'b1101, 8'h40, 8'h00, "R5 zero taken");
        jump_at(4'b1101, 8'h60, 8'h01, "R5 zero not taken");
        jump_at(4'b1011, 8'h22, 8'h10, "R6 half carry taken");
        jump_at(4'b1011, 8'h33, 8'hEF, "R6 half carry not taken");
        jump_at(4'b0111, 8'h77, 8'h80, "R7 sign taken");
        jump_at(4'b0111, 8'h88, 8'h7F, "R7 sign not taken");
    endtask

    task automatic t_prio();
        jump_at(4'b0101, 8'h11, 8'h80, "R10 zero over sign");
        jump_at(4'b1100, 8'h2C, 8'h05, "R10 long over zero");
        jump_at(4'b0011, 8'h99, 8'h80, "R10 half over sign");
        jump_at(4'b1001, 8'hAB, 8'h00, "R10 zero over half");
    endtask

    task automatic t_edge();
        go_to(16'h66FE);
        jump_at(4'b1101, 8'h20, 8'h00, "R5 taken at page end");
        go_to(16'h66FE);
        jump_at(4'b1101, 8'h20, 8'h01, "R3 not taken at page end wraps");
    endtask

    initial begin
        t_reset();
        t_count();
        t_wrap();
        t_long();
        t_cond();
        t_prio();
        t_edge();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 8);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog all actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule